// File: doc/BRIEF.md
# GPIO Interrupt Style Detector

This block watches sixteen general-purpose input pins and raises a sticky interrupt flag for each pin whose synchronised level or transition matches that pin's programmed trigger style. Each flag drives its own interrupt line toward a downstream interrupt controller. Software selects one of five styles per pin: high level, low level, rising edge, falling edge, or any transition. It also chooses which pins take part through a direction mask, and clears flags by writing ones to the status register.

Pin inputs pass through a two-flop synchroniser. Edges are found by comparing the synchronised value with its value one cycle earlier. Style fields are three bits wide and are split across two bank registers of eight fields each. Configuration uses a single-cycle register port with a combinational read path.

Top module: `gpio_irq_detect`

## Requirements
- R1: After reset every status bit and every irq_o line is 0. Both style banks read back 0x00FFFFFF (every field is code 7), and the direction register reads 0.
- R2: Style code 0 (level high) sets a pin's status in every cycle in which its synchronised input is 1.
- R3: Style code 1 (level low) sets a pin's status in every cycle in which its synchronised input is 0.
- R4: Style code 2 sets status on a 0-to-1 synchronised transition, code 3 on a 1-to-0 transition, and code 4 on either transition.
- R5: Style codes 5, 6 and 7 never set a pin's status.
- R6: Address 0 holds the style fields of pins 0 to 7, and address 1 holds those of pins 8 to 15. Pin n uses bits [3k+2:3k] with k = n mod 8. Bits 31:24 of both banks read back 0.
- R7: Address 2 is the status register. Writing 1 to a bit clears it, and writing 0 leaves it unchanged. irq_o always equals the status register, and a status bit is set only by a detection.
- R8: While a level condition persists, a status clear has no effect and the bit stays 1. Once the condition is gone, a clear succeeds.
- R9: Address 3 is the direction register, where bit n = 1 marks pin n as an input. A pin whose direction bit is 0 never sets its status.
- R10: A change on pin_i that is held stable is visible in status on the third rising clock edge after it is applied.
- R11: When a status clear and a new detection hit the same bit in the same cycle, the bit ends up set.
- R12: The sequence of disabling the style field, clearing the status bit and writing a new edge style leaves no event pending. Only transitions that occur after the new style is in place set status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pin_i | input | 16 | Asynchronous pin levels |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address (0,1 style banks, 2 status, 3 direction) |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i (combinational) |
| irq_o | output | 16 | Per-pin interrupt lines (status register) |

## Verification
Random pin waveforms are run against random style, direction and status writes. This separates the five style codes from one another and from the disabled codes, because level styles fire on steady inputs while edge styles fire only on transitions. Directed sequences cover the following cases:
- the three-edge latency from a pin change;
- a clear made while a high level persists, which separates the level styles' hold behaviour from plain write-one-to-clear;
- a clear that lands in the same cycle as a rising edge, which shows whether detection takes priority;
- the disable, clear and restyle order, with the pin held steady, which exposes a leftover edge.

A pin in the upper bank is used to confirm the field offset within the second register.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  typedef enum logic [2:0] {
    STY_HIGH = 3'd0,
    STY_LOW  = 3'd1,
    STY_RISE = 3'd2,
    STY_FALL = 3'd3,
    STY_ANY  = 3'd4,
    STY_OFF  = 3'd7
  } style_e;

  localparam logic [1:0] ADDR_STY_LO = 2'd0;
  localparam logic [1:0] ADDR_STY_HI = 2'd1;
  localparam logic [1:0] ADDR_STATUS = 2'd2;
  localparam logic [1:0] ADDR_DIR    = 2'd3;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 16,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] cur_o,
  output logic [WIDTH-1:0] prev_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < STAGES; k++) stage_q[k] <= '0;
      prev_o <= '0;
    end else begin
      stage_q[0] <= pin_i;
      for (int k = 1; k < STAGES; k++) stage_q[k] <= stage_q[k-1];
      prev_o <= stage_q[STAGES-1];
    end
  end

  assign cur_o = stage_q[STAGES-1];

  // cycles since reset, saturating
  logic [1:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  generate
    if (STAGES == 2) begin : g_chk
      assert_sync_latency_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (age_q >= 2'd2) |-> (cur_o == $past(pin_i, 2)));
    end
  endgenerate
endmodule

// File: rtl/gpio_style_eval.sv
module gpio_style_eval
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 16,
  parameter int STYLE_W  = 3
) (
  input  logic [NUM_PINS-1:0]         cur_i,
  input  logic [NUM_PINS-1:0]         prev_i,
  input  logic [NUM_PINS-1:0]         dir_i,
  input  logic [NUM_PINS*STYLE_W-1:0] style_i,
  output logic [NUM_PINS-1:0]         hit_o
);
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic [STYLE_W-1:0] sty;
    logic               det;
    assign sty = style_i[p*STYLE_W +: STYLE_W];
    always_comb begin
      unique case (sty)
        STY_HIGH: det = cur_i[p];
        STY_LOW:  det = !cur_i[p];
        STY_RISE: det = cur_i[p] && !prev_i[p];
        STY_FALL: det = !cur_i[p] && prev_i[p];
        STY_ANY:  det = cur_i[p] ^ prev_i[p];
        default:  det = 1'b0;
      endcase
    end
    assign hit_o[p] = dir_i[p] && det;
  end
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 16,
  parameter int STYLE_W  = 3,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 2
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        we_i,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [DATA_W-1:0]           wdata_i,
  input  logic [NUM_PINS-1:0]         hit_i,
  output logic [DATA_W-1:0]           rdata_o,
  output logic [NUM_PINS*STYLE_W-1:0] style_o,
  output logic [NUM_PINS-1:0]         dir_o,
  output logic [NUM_PINS-1:0]         status_o
);
  localparam int FIELDS = NUM_PINS / 2;
  localparam int BANK_W = FIELDS * STYLE_W;

  logic [BANK_W-1:0]   sty_lo_q, sty_hi_q;
  logic [NUM_PINS-1:0] dir_q, status_q, w1c;

  logic unused_wdata;
  assign unused_wdata = ^wdata_i[DATA_W-1:BANK_W];

  assign w1c = (we_i && addr_i == ADDR_STATUS) ? wdata_i[NUM_PINS-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sty_lo_q <= '1;
      sty_hi_q <= '1;
      dir_q    <= '0;
      status_q <= '0;
    end else begin
      // detection overrides a clear of the same bit
      status_q <= (status_q & ~w1c) | hit_i;
      if (we_i) begin
        unique case (addr_i)
          ADDR_STY_LO: sty_lo_q <= wdata_i[BANK_W-1:0];
          ADDR_STY_HI: sty_hi_q <= wdata_i[BANK_W-1:0];
          ADDR_DIR:    dir_q    <= wdata_i[NUM_PINS-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_STY_LO: rdata_o[BANK_W-1:0]   = sty_lo_q;
      ADDR_STY_HI: rdata_o[BANK_W-1:0]   = sty_hi_q;
      ADDR_STATUS: rdata_o[NUM_PINS-1:0] = status_q;
      default:     rdata_o[NUM_PINS-1:0] = dir_q;
    endcase
  end

  assign style_o  = {sty_hi_q, sty_lo_q};
  assign dir_o    = dir_q;
  assign status_o = status_q;

  assert_no_spurious_set_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((status_q & ~$past(status_q) & ~$past(hit_i)) == '0));
  assert_clear_only_w1c_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(status_q) & ~status_q & ~$past(w1c)) == '0));
  assert_hit_wins_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(hit_i) & ~status_q) == '0));
  assert_dir_gate_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((status_q & ~$past(status_q) & ~$past(dir_q)) == '0));
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 16,
  parameter int STYLE_W  = 3,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic                reg_we_i,
  input  logic [ADDR_W-1:0]   reg_addr_i,
  input  logic [DATA_W-1:0]   reg_wdata_i,
  output logic [DATA_W-1:0]   reg_rdata_o,
  output logic [NUM_PINS-1:0] irq_o
);
  logic [NUM_PINS-1:0]         cur, prev, hit, dir;
  logic [NUM_PINS*STYLE_W-1:0] style;

  gpio_sync #(.WIDTH(NUM_PINS), .STAGES(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pin_i (pin_i),
    .cur_o (cur),
    .prev_o(prev)
  );

  gpio_style_eval #(.NUM_PINS(NUM_PINS), .STYLE_W(STYLE_W)) u_eval (
    .cur_i  (cur),
    .prev_i (prev),
    .dir_i  (dir),
    .style_i(style),
    .hit_o  (hit)
  );

  gpio_irq_regs #(.NUM_PINS(NUM_PINS), .STYLE_W(STYLE_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .hit_i   (hit),
    .rdata_o (reg_rdata_o),
    .style_o (style),
    .dir_o   (dir),
    .status_o(irq_o)
  );
endmodule

// File: tb/gpio_irq_detect_bench.sv
`timescale 1ns/1ps
module gpio_irq_detect_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] pin = '0;
  logic        we = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [15:0] irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  gpio_irq_detect u_gpio_irq_detect (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .reg_we_i(we),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
  );

  // reference model state
  logic [15:0] m_s1, m_s, m_prev, m_status, m_dir;
  logic [23:0] m_lo, m_hi;

  function automatic logic [2:0] field(input logic [23:0] lo, input logic [23:0] hi, input int p);
    logic [23:0] b = (p < 8) ? lo : hi;
    return b[(p%8)*3 +: 3];
  endfunction

  function automatic logic [15:0] exp_hit(input logic [15:0] c, input logic [15:0] pv,
                                          input logic [15:0] d, input logic [23:0] lo,
                                          input logic [23:0] hi);
    logic [15:0] h = '0;
    for (int p = 0; p < 16; p++) begin
      logic e;
      case (field(lo, hi, p))
        3'd0: e = c[p];
        3'd1: e = !c[p];
        3'd2: e = c[p] & !pv[p];
        3'd3: e = !c[p] & pv[p];
        3'd4: e = c[p] ^ pv[p];
        default: e = 1'b0;
      endcase
      h[p] = e & d[p];
    end
    return h;
  endfunction

  function automatic logic [23:0] bank(input logic [2:0] c);
    logic [23:0] b;
    for (int k = 0; k < 8; k++) b[k*3 +: 3] = c;
    return b;
  endfunction

  function automatic logic [23:0] put(input logic [23:0] b, input int k, input logic [2:0] c);
    logic [23:0] r = b;
    r[k*3 +: 3] = c;
    return r;
  endfunction

  task automatic check(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_s1 = '0; m_s = '0; m_prev = '0; m_status = '0; m_dir = '0;
    m_lo = 24'hFFFFFF; m_hi = 24'hFFFFFF;
  endtask

  function automatic logic [31:0] model_read(input logic [1:0] a);
    case (a)
      2'd0: return {8'h0, m_lo};
      2'd1: return {8'h0, m_hi};
      2'd2: return {16'h0, m_status};
      default: return {16'h0, m_dir};
    endcase
  endfunction

  task automatic step(input string tag, input logic [15:0] p, input logic w,
                      input logic [1:0] a, input logic [31:0] d);
    logic [15:0] h, clr;
    @(negedge clk);
    pin = p; we = w; addr = a; wdata = d;
    #1;
    if (!w) check(tag, "readback", rdata, model_read(a));
    @(posedge clk);
    h = exp_hit(m_s, m_prev, m_dir, m_lo, m_hi);
    clr = (w && a == 2'd2) ? d[15:0] : '0;
    m_status = (m_status & ~clr) | h;
    if (w) begin
      case (a)
        2'd0: m_lo = d[23:0];
        2'd1: m_hi = d[23:0];
        2'd3: m_dir = d[15:0];
        default: ;
      endcase
    end
    m_prev = m_s; m_s = m_s1; m_s1 = p;
    #1;
    check(tag, "irq", {16'h0, irq}, {16'h0, m_status});
  endtask

  task automatic wr(input string tag, input logic [1:0] a, input logic [31:0] d);
    step(tag, pin, 1'b1, a, d);
  endtask

  task automatic idle(input string tag, input int n, input logic [15:0] p);
    for (int i = 0; i < n; i++) step(tag, p, 1'b0, 2'(i % 4), 32'h0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset values
    idle("R1", 4, 16'h0);

    // R6: banked fields; pin 0 level high, pin 9 rising (upper bank field 1)
    wr("R6", 2'd0, {8'hAB, put(bank(3'd7), 0, 3'd0)});
    wr("R6", 2'd1, {8'hCD, put(bank(3'd7), 1, 3'd2)});
    idle("R6", 4, 16'h0);
    wr("R9", 2'd3, 32'hFFFF);

    // R10 and R2: pin 0 high, appears on third edge
    step("R10", 16'h0001, 1'b0, 2'd2, 0);
    step("R10", 16'h0001, 1'b0, 2'd2, 0);
    step("R10", 16'h0001, 1'b0, 2'd2, 0);
    check("R10", "irq bit0 on third edge", {31'h0, irq[0]}, 32'h1);
    // R8: clear ignored while level holds
    step("R8", 16'h0001, 1'b1, 2'd2, 32'h0001);
    step("R8", 16'h0001, 1'b1, 2'd2, 32'h0001);
    check("R8", "held bit0", {31'h0, irq[0]}, 32'h1);
    idle("R8", 3, 16'h0000);
    step("R7", 16'h0000, 1'b1, 2'd2, 32'h0000);
    check("R7", "zero write keeps", {31'h0, irq[0]}, 32'h1);
    step("R7", 16'h0000, 1'b1, 2'd2, 32'h0001);
    check("R7", "clear bit0", {31'h0, irq[0]}, 32'h0);

    // R11: clear every cycle while pin 9 rises
    for (int i = 0; i < 5; i++) step("R11", 16'h0200, 1'b1, 2'd2, 32'h0200);
    step("R11", 16'h0200, 1'b1, 2'd2, 32'h0200);
    check("R11", "bit9 cleared after edge", {31'h0, irq[9]}, 32'h0);

    // R12: restyle sequence, pin 9 held high
    wr("R12", 2'd1, bank(3'd7));
    wr("R12", 2'd2, 32'hFFFF);
    wr("R12", 2'd1, put(bank(3'd7), 1, 3'd3));
    idle("R12", 5, 16'h0200);
    check("R12", "no stale event", {31'h0, irq[9]}, 32'h0);
    idle("R12", 4, 16'h0000);
    check("R12", "fall after restyle", {31'h0, irq[9]}, 32'h1);
    wr("R12", 2'd2, 32'hFFFF);

    // R3, R4: low level, falling, any
    wr("R3", 2'd0, {put(put(put(bank(3'd7), 2, 3'd1), 3, 3'd3), 4, 3'd4)});
    idle("R3", 4, 16'h001C);
    wr("R4", 2'd2, 32'hFFFF);
    idle("R4", 4, 16'h0000);
    idle("R4", 4, 16'h001C);

    // R5: disabled codes
    wr("R5", 2'd0, bank(3'd5));
    wr("R5", 2'd1, bank(3'd6));
    wr("R5", 2'd2, 32'hFFFF);
    for (int i = 0; i < 12; i++) step("R5", 16'(i[0] ? 16'hFFFF : 16'h0), 1'b0, 2'd2, 0);
    check("R5", "no irq", {16'h0, irq}, 32'h0);

    // R9: direction all outputs, level high everywhere
    wr("R9", 2'd3, 32'h0);
    wr("R9", 2'd0, bank(3'd0));
    wr("R9", 2'd1, bank(3'd0));
    idle("R9", 6, 16'hFFFF);
    check("R9", "gated", {16'h0, irq}, 32'h0);

    // random run
    for (int i = 0; i < 4000; i++) begin
      logic [15:0] rp = 16'($urandom);
      if ($urandom_range(9) == 0)
        step("R2", rp, 1'b1, 2'($urandom_range(3)), $urandom);
      else
        step("R4", rp, 1'b0, 2'($urandom_range(3)), 0);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule